// File: doc/BRIEF.md
# Frame Buffer Line Fetch Address Generator

This block walks one display layer's frame buffer in memory and issues the read requests that fill that layer's pixel FIFO ahead of the display. Software sets a base address, the number of bytes to fetch per line, the byte stride between line starts and the number of lines. After a frame-start pulse the block fetches each line from its start in bursts of at most 64 bytes. It then moves to the next line by the stride, and it stops once the last line has been fetched. The stride is separate from the fetched length, so a line can be narrower than the stored row.

The block also keeps a running byte level for the FIFO. The level rises when a request is granted and falls when the display consumes a 4-byte word. A consume that finds less than a word in the FIFO is an underrun, and it raises a sticky flag if underrun reporting is enabled. When the display closes a line before it has used all the bytes fetched for that line, the unused bytes are reported as discarded and taken out of the level. The level may go below zero, so bytes still on their way are dropped when they arrive.

Top module: `fbFetchGen`

## Requirements
- R1: After reset, reqValid, fetchActive, underrunFlag and discardPulse are all 0.
- R2: A frameStart pulse with a non-zero line length and a non-zero line count sets fetchActive on the next cycle. No request is raised in the cycle after the pulse. The first request of the frame carries cfgStartAddr.
- R3: Within a line, each request's byte count is the smaller of 64 and the bytes left in the line. Each request's address is the previous one plus the previous byte count, so the counts of one line sum to the line length.
- R4: The first request of line n (counting from 0) carries cfgStartAddr + n × cfgPitch, modulo 2^32.
- R5: fetchActive falls on the cycle after the grant that completes line cfgLineCount−1. No request is raised while fetchActive is 0.
- R6: reqValid rises only if, in the previous cycle, fetchActive was 1, layerEn was 1, fifoFree was at least 64 and frameStart was 0. After every grant, reqValid is 0 for at least one cycle.
- R7: While reqValid is 1 and reqReady is 0, reqValid stays 1 and reqAddr and reqBytes stay unchanged on the next cycle.
- R8: The level is the bytes granted, minus 4 for each accepted consume, minus the discarded bytes, counted since the last frameStart. A dispPop while the level is below 4 is an underrun: the consume is ignored, and underrunFlag becomes 1 on the next cycle if underrunEn is 1. underrunFlag stays set until underrunClr. A new underrun in the same cycle as underrunClr leaves the flag set.
- R9: On dispLineEnd, if the bytes consumed since the previous dispLineEnd (including a consume in the same cycle) are fewer than cfgLineLen, discardPulse is 1 on the next cycle. discardBytes then holds the difference, and that difference is removed from the level. Otherwise discardPulse is 0.
- R10: A grant and an accepted consume in the same cycle both change the level. The underrun test in that cycle uses the level from before the cycle.
- R11: A frameStart with cfgLineLen = 0 or cfgLineCount = 0 leaves fetchActive at 0 and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| layerEn | input | 1 | Layer enable; when low, no new request is raised |
| frameStart | input | 1 | Pulse that reloads the walk at the top of a frame |
| cfgStartAddr | input | ADDR_W | Byte address of the first line |
| cfgLineLen | input | LEN_W | Bytes fetched per line |
| cfgPitch | input | LEN_W | Byte distance between consecutive line starts |
| cfgLineCount | input | LINE_W | Lines per frame |
| fifoFree | input | FREE_W | Free bytes reported by the pixel FIFO |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request accepted by memory |
| reqAddr | output | ADDR_W | Request byte address |
| reqBytes | output | BURST_W | Request byte count (1 to 64) |
| fetchActive | output | 1 | High while lines remain to be fetched in this frame |
| dispPop | input | 1 | Display consumes one 4-byte word |
| dispLineEnd | input | 1 | Display has finished its current line |
| underrunEn | input | 1 | Enables reporting of underruns |
| underrunClr | input | 1 | Write-one-to-clear for underrunFlag |
| underrunFlag | output | 1 | Sticky underrun indication |
| discardPulse | output | 1 | One-cycle pulse when unused bytes of a line are dropped |
| discardBytes | output | LEN_W | Number of bytes dropped, valid with discardPulse |

## Verification
Two functions can act on the FIFO level in the same cycle: a grant of a request, which raises the level, and a display consume, which lowers it or is refused as an underrun. Frames are run with reqReady, fifoFree and dispPop held high, so that grants and consumes overlap on most cycles. Other frames use a dense mix of dispLineEnd pulses, so that discards also land on grant cycles. A bench model updates the level with the pre-cycle value for the underrun test and applies all three changes together. The result is judged through the underrunFlag and discardBytes the design reports on the following cycles.

// File: rtl/fbFetchPkg.sv
package fbFetchPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadFrame;   // reload walk and level at top of frame
    logic issueReq;    // capture a new request into the output registers
    logic acceptReq;   // current request granted this cycle
  } fetchStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fetchState_t;

endpackage

// File: rtl/fbFetchCtrl.sv
module fbFetchCtrl
  import fbFetchPkg::*;
#(
  parameter int FREE_W      = 12,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              layerEn,
  input  logic [FREE_W-1:0] fifoFree,
  input  logic              reqReady,
  input  logic              cfgOk,
  input  logic              lineDone,
  input  logic              lastLine,
  output logic              reqValid,
  output logic              fetchActive,
  output fetchStrobe_t      strobe
);

  localparam logic [FREE_W-1:0] NEED_FREE = FREE_W'(BURST_BYTES);

  fetchState_t state, stateNext;
  logic        validNext;
  logic        roomOk;

  assign roomOk = (fifoFree >= NEED_FREE);

  always_comb begin
    strobe.loadFrame = frameStart;
    strobe.acceptReq = reqValid && reqReady;
    // a new request only from an idle handshake, never in a frame-start cycle
    strobe.issueReq  = (state == ST_RUN) && !reqValid && layerEn && roomOk && !frameStart;
  end

  always_comb begin
    stateNext = state;
    if (frameStart) begin
      stateNext = cfgOk ? ST_RUN : ST_IDLE;
    end else if (strobe.acceptReq && lineDone && lastLine) begin
      stateNext = ST_IDLE;
    end
  end

  always_comb begin
    validNext = reqValid;
    if (strobe.issueReq) begin
      validNext = 1'b1;
    end else if (strobe.acceptReq) begin
      validNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqValid <= 1'b0;
    end else begin
      state    <= stateNext;
      reqValid <= validNext;
    end
  end

  assign fetchActive = (state == ST_RUN);

endmodule

// File: rtl/fbFetchPath.sv
module fbFetchPath
  import fbFetchPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 13,
  parameter int LINE_W      = 11,
  parameter int BURST_BYTES = 64,
  parameter int BURST_W     = 7,
  parameter int POP_BYTES   = 4,
  parameter int AVAIL_W     = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchStrobe_t       strobe,
  input  logic [ADDR_W-1:0]  cfgStartAddr,
  input  logic [LEN_W-1:0]   cfgLineLen,
  input  logic [LEN_W-1:0]   cfgPitch,
  input  logic [LINE_W-1:0]  cfgLineCount,
  input  logic               dispPop,
  input  logic               dispLineEnd,
  input  logic               underrunEn,
  input  logic               underrunClr,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [BURST_W-1:0] reqBytes,
  output logic               cfgOk,
  output logic               lineDone,
  output logic               lastLine,
  output logic               underrunFlag,
  output logic               discardPulse,
  output logic [LEN_W-1:0]   discardBytes
);

  localparam logic [LEN_W-1:0]   BURST_LEN = LEN_W'(BURST_BYTES);
  localparam logic [AVAIL_W-1:0] POP_AMT   = AVAIL_W'(POP_BYTES);

  // ---------------- line walk ----------------
  logic [ADDR_W-1:0]  lineAddr;
  logic [LEN_W-1:0]   byteOff;
  logic [LINE_W-1:0]  lineIdx;
  logic [LEN_W-1:0]   remLine;
  logic [BURST_W-1:0] burstLen;
  logic [LEN_W:0]     offAfter;
  logic [LINE_W:0]    lineNext;

  assign remLine  = cfgLineLen - byteOff;
  assign burstLen = (remLine > BURST_LEN) ? BURST_W'(BURST_BYTES) : BURST_W'(remLine);
  assign offAfter = {1'b0, byteOff} + (LEN_W+1)'(reqBytes);
  assign lineDone = (offAfter >= {1'b0, cfgLineLen});
  assign lineNext = {1'b0, lineIdx} + (LINE_W+1)'(1);
  assign lastLine = (lineNext >= {1'b0, cfgLineCount});
  assign cfgOk    = (cfgLineLen != '0) && (cfgLineCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddr <= '0;
      byteOff  <= '0;
      lineIdx  <= '0;
    end else if (strobe.loadFrame) begin
      lineAddr <= cfgStartAddr;
      byteOff  <= '0;
      lineIdx  <= '0;
    end else if (strobe.acceptReq) begin
      if (lineDone) begin
        byteOff  <= '0;
        lineAddr <= lineAddr + ADDR_W'(cfgPitch);
        lineIdx  <= lineNext[LINE_W-1:0];
      end else begin
        byteOff  <= offAfter[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqBytes <= '0;
    end else if (strobe.issueReq) begin
      reqAddr  <= lineAddr + ADDR_W'(byteOff);
      reqBytes <= burstLen;
    end
  end

  // ---------------- FIFO level and display side ----------------
  logic signed [AVAIL_W-1:0] level, levelNext;
  logic        [AVAIL_W-1:0] rdPos, rdNext;
  logic        [AVAIL_W-1:0] accAmt, popAmt, discAmt, lenExt;
  logic                      popOk, underrunEvt;

  assign lenExt      = AVAIL_W'(cfgLineLen);
  assign popOk       = dispPop && (level >= $signed(POP_AMT));
  assign underrunEvt = dispPop && !popOk;
  assign popAmt      = popOk ? POP_AMT : '0;
  assign accAmt      = strobe.acceptReq ? AVAIL_W'(reqBytes) : '0;
  assign rdNext      = rdPos + popAmt;
  assign discAmt     = (dispLineEnd && (rdNext < lenExt)) ? (lenExt - rdNext) : '0;
  assign levelNext   = level + $signed(accAmt) - $signed(popAmt) - $signed(discAmt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
      rdPos <= '0;
    end else if (strobe.loadFrame) begin
      level <= '0;
      rdPos <= '0;
    end else begin
      level <= levelNext;
      rdPos <= dispLineEnd ? '0 : rdNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrunFlag <= 1'b0;
    end else if (underrunEvt && underrunEn) begin
      underrunFlag <= 1'b1;
    end else if (underrunClr) begin
      underrunFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discardPulse <= 1'b0;
      discardBytes <= '0;
    end else begin
      discardPulse <= dispLineEnd && (discAmt != '0);
      discardBytes <= discAmt[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/fbFetchGen.sv
module fbFetchGen
  import fbFetchPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 13,
  parameter int LINE_W      = 11,
  parameter int FREE_W      = 12,
  parameter int BURST_BYTES = 64,
  parameter int POP_BYTES   = 4,
  localparam int BURST_W    = $clog2(BURST_BYTES + 1),
  localparam int AVAIL_W    = LEN_W + LINE_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               layerEn,
  input  logic               frameStart,
  input  logic [ADDR_W-1:0]  cfgStartAddr,
  input  logic [LEN_W-1:0]   cfgLineLen,
  input  logic [LEN_W-1:0]   cfgPitch,
  input  logic [LINE_W-1:0]  cfgLineCount,
  input  logic [FREE_W-1:0]  fifoFree,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [BURST_W-1:0] reqBytes,
  output logic               fetchActive,
  input  logic               dispPop,
  input  logic               dispLineEnd,
  input  logic               underrunEn,
  input  logic               underrunClr,
  output logic               underrunFlag,
  output logic               discardPulse,
  output logic [LEN_W-1:0]   discardBytes
);

  fetchStrobe_t strobe;
  logic         cfgOk, lineDone, lastLine;

  fbFetchCtrl #(
    .FREE_W      (FREE_W),
    .BURST_BYTES (BURST_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStart  (frameStart),
    .layerEn     (layerEn),
    .fifoFree    (fifoFree),
    .reqReady    (reqReady),
    .cfgOk       (cfgOk),
    .lineDone    (lineDone),
    .lastLine    (lastLine),
    .reqValid    (reqValid),
    .fetchActive (fetchActive),
    .strobe      (strobe)
  );

  fbFetchPath #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .LINE_W      (LINE_W),
    .BURST_BYTES (BURST_BYTES),
    .BURST_W     (BURST_W),
    .POP_BYTES   (POP_BYTES),
    .AVAIL_W     (AVAIL_W)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgStartAddr (cfgStartAddr),
    .cfgLineLen   (cfgLineLen),
    .cfgPitch     (cfgPitch),
    .cfgLineCount (cfgLineCount),
    .dispPop      (dispPop),
    .dispLineEnd  (dispLineEnd),
    .underrunEn   (underrunEn),
    .underrunClr  (underrunClr),
    .reqAddr      (reqAddr),
    .reqBytes     (reqBytes),
    .cfgOk        (cfgOk),
    .lineDone     (lineDone),
    .lastLine     (lastLine),
    .underrunFlag (underrunFlag),
    .discardPulse (discardPulse),
    .discardBytes (discardBytes)
  );

endmodule

// File: rtl/fbFetchChecker.sv
module fbFetchChecker #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 13,
  parameter int FREE_W      = 12,
  parameter int BURST_BYTES = 64,
  parameter int BURST_W     = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               layerEn,
  input logic               frameStart,
  input logic [FREE_W-1:0]  fifoFree,
  input logic               reqValid,
  input logic               reqReady,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [BURST_W-1:0] reqBytes,
  input logic               fetchActive,
  input logic               underrunClr,
  input logic               underrunFlag,
  input logic               discardPulse,
  input logic [LEN_W-1:0]   discardBytes
);

  // R7: a stalled request is held unchanged
  assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqBytes)));

  // R3: byte count is never zero and never beyond one burst
  assert_burst_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((reqBytes != '0) && (32'(reqBytes) <= BURST_BYTES)));

  // R6: a new request needs room, enable and no frame start one cycle earlier
  assert_issue_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> ((32'($past(fifoFree)) >= BURST_BYTES) && $past(layerEn)
                         && !$past(frameStart) && $past(fetchActive)));

  // R5: nothing is requested once the frame walk has ended
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fetchActive |-> !reqValid);

  // R2: the cycle after a frame start carries no request
  assert_start_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !reqValid);

  // R8: the underrun flag is sticky until cleared
  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !underrunClr) |=> underrunFlag);

  // R9: a discard pulse always reports a non-zero amount
  assert_discard_amount_R9: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> (discardBytes != '0));

endmodule

bind fbFetchGen fbFetchChecker #(
  .ADDR_W      (ADDR_W),
  .LEN_W       (LEN_W),
  .FREE_W      (FREE_W),
  .BURST_BYTES (BURST_BYTES),
  .BURST_W     (BURST_W)
) u_fbFetchChecker (
  .clk          (clk),
  .rstN         (rstN),
  .layerEn      (layerEn),
  .frameStart   (frameStart),
  .fifoFree     (fifoFree),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqAddr      (reqAddr),
  .reqBytes     (reqBytes),
  .fetchActive  (fetchActive),
  .underrunClr  (underrunClr),
  .underrunFlag (underrunFlag),
  .discardPulse (discardPulse),
  .discardBytes (discardBytes)
);

// File: tb/fbFetchGen_bench.sv
module fbFetchGen_bench;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 13;
  localparam int LINE_W = 11;
  localparam int FREE_W = 12;
  localparam int BURST  = 64;
  localparam int POP    = 4;
  localparam int BW     = $clog2(BURST + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              layerEn, frameStart, reqReady, dispPop, dispLineEnd;
  logic              underrunEn, underrunClr;
  logic [ADDR_W-1:0] cfgStartAddr;
  logic [LEN_W-1:0]  cfgLineLen, cfgPitch;
  logic [LINE_W-1:0] cfgLineCount;
  logic [FREE_W-1:0] fifoFree;
  logic              reqValid, fetchActive, underrunFlag, discardPulse;
  logic [ADDR_W-1:0] reqAddr;
  logic [BW-1:0]     reqBytes;
  logic [LEN_W-1:0]  discardBytes;

  always #10 clk = ~clk;  // 50 MHz

  fbFetchGen u_fbFetchGen (
    .clk(clk), .rstN(rstN), .layerEn(layerEn), .frameStart(frameStart),
    .cfgStartAddr(cfgStartAddr), .cfgLineLen(cfgLineLen), .cfgPitch(cfgPitch),
    .cfgLineCount(cfgLineCount), .fifoFree(fifoFree), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqBytes(reqBytes),
    .fetchActive(fetchActive), .dispPop(dispPop), .dispLineEnd(dispLineEnd),
    .underrunEn(underrunEn), .underrunClr(underrunClr), .underrunFlag(underrunFlag),
    .discardPulse(discardPulse), .discardBytes(discardBytes)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  longint mLineAddr;
  int     mOff, mLine, mAvail, mRd;
  bit     mActive, mFlag;

  // stimulus knobs (percentages)
  int kReady = 80, kFree = 80, kPop = 30, kLineEnd = 3, kClr = 5, kEn = 95, kUrEn = 70;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int burstOf(input int remain);
    return (remain > BURST) ? BURST : remain;
  endfunction

  task automatic randInputs();
    int pick;
    reqReady    = ($urandom_range(99) < kReady);
    pick        = $urandom_range(99);
    if (pick < 10)         fifoFree = FREE_W'(63);
    else if (pick < 20)    fifoFree = FREE_W'(64);
    else if (pick < kFree) fifoFree = FREE_W'($urandom_range(4095, 64));
    else                   fifoFree = FREE_W'($urandom_range(63));
    dispPop     = ($urandom_range(99) < kPop);
    dispLineEnd = ($urandom_range(99) < kLineEnd);
    underrunClr = ($urandom_range(99) < kClr);
    underrunEn  = ($urandom_range(99) < kUrEn);
    layerEn     = ($urandom_range(99) < kEn);
    frameStart  = 1'b0;
  endtask

  // One clock: predict from inputs now, step, compare outputs.
  task automatic doCycle();
    bit     acc, popOk, evt, expValid, preActive, holdCase, expDisc;
    int     expB, rdNext, disc, accB, len, cnt;
    longint expA, heldA, heldB;
    string  tg;
    len       = int'(cfgLineLen);
    cnt       = int'(cfgLineCount);
    preActive = mActive;
    acc       = reqValid && reqReady;
    holdCase  = reqValid && !reqReady;
    heldA     = longint'(reqAddr);
    heldB     = longint'(reqBytes);
    accB      = 0;
    if (acc) begin
      expB = burstOf(len - mOff);
      expA = (mLineAddr + mOff) & 64'hFFFF_FFFF;
      tg   = (mLine == 0 && mOff == 0) ? "R2" : ((mOff == 0) ? "R4" : "R3");
      check(longint'(reqAddr) == expA, tg, "request address", longint'(reqAddr), expA);
      check(int'(reqBytes) == expB, "R3", "request bytes", longint'(reqBytes), expB);
      accB = expB;
      if (mOff + expB >= len) begin
        mOff      = 0;
        mLineAddr = (mLineAddr + int'(cfgPitch)) & 64'hFFFF_FFFF;
        mLine++;
        if (mLine >= cnt) mActive = 0;
      end else begin
        mOff = mOff + expB;
      end
    end
    popOk  = dispPop && (mAvail >= POP);
    evt    = dispPop && !popOk;
    rdNext = mRd + (popOk ? POP : 0);
    disc   = (dispLineEnd && rdNext < len) ? (len - rdNext) : 0;
    if (frameStart) begin
      mAvail = 0; mRd = 0; mOff = 0; mLine = 0;
      mLineAddr = longint'(cfgStartAddr);
      mActive   = (len != 0) && (cnt != 0);
    end else begin
      mAvail = mAvail + accB - (popOk ? POP : 0) - disc;
      mRd    = dispLineEnd ? 0 : rdNext;
    end
    expValid = reqValid ? !acc
                        : (preActive && layerEn && (int'(fifoFree) >= BURST) && !frameStart);
    if (evt && underrunEn) mFlag = 1;
    else if (underrunClr)  mFlag = 0;
    expDisc = dispLineEnd && (disc != 0);

    @(posedge clk);
    @(negedge clk);

    check(reqValid == expValid, holdCase ? "R7" : "R6", "reqValid", reqValid, expValid);
    if (holdCase) begin
      check(longint'(reqAddr) == heldA, "R7", "held address", longint'(reqAddr), heldA);
      check(longint'(reqBytes) == heldB, "R7", "held bytes", longint'(reqBytes), heldB);
    end
    tg = frameStart ? (((len != 0) && (cnt != 0)) ? "R2" : "R11") : "R5";
    check(fetchActive == mActive, tg, "fetchActive", fetchActive, mActive);
    tg = (acc && popOk) ? "R10" : "R8";
    check(underrunFlag == mFlag, tg, "underrunFlag", underrunFlag, mFlag);
    check(discardPulse == expDisc, "R9", "discardPulse", discardPulse, expDisc);
    if (expDisc)
      check(int'(discardBytes) == disc, "R9", "discardBytes", longint'(discardBytes), disc);
  endtask

  task automatic runFrame(input longint start, input int len, input int pitch, input int cnt);
    int k;
    while (reqValid) begin
      randInputs();
      doCycle();
    end
    cfgStartAddr = ADDR_W'(start);
    cfgLineLen   = LEN_W'(len);
    cfgPitch     = LEN_W'(pitch);
    cfgLineCount = LINE_W'(cnt);
    randInputs();
    frameStart  = 1'b1;
    dispPop     = 1'b0;
    dispLineEnd = 1'b0;
    doCycle();
    k = 0;
    while ((fetchActive || reqValid) && k < 6000) begin
      randInputs();
      doCycle();
      k++;
    end
    for (int j = 0; j < 16; j++) begin
      randInputs();
      doCycle();
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; layerEn = 0; frameStart = 0; reqReady = 0; dispPop = 0;
    dispLineEnd = 0; underrunEn = 0; underrunClr = 0; fifoFree = '0;
    cfgStartAddr = '0; cfgLineLen = '0; cfgPitch = '0; cfgLineCount = '0;
    mLineAddr = 0; mOff = 0; mLine = 0; mAvail = 0; mRd = 0; mActive = 0; mFlag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);
    check(fetchActive == 1'b0, "R1", "fetchActive after reset", fetchActive, 0);
    check(underrunFlag == 1'b0, "R1", "underrunFlag after reset", underrunFlag, 0);
    check(discardPulse == 1'b0, "R1", "discardPulse after reset", discardPulse, 0);

    // R8: underrun set and clear in the same cycle, set wins; then clear; then disabled
    cfgStartAddr = 32'h0000_4000; cfgLineLen = 13'd64; cfgPitch = 13'd64; cfgLineCount = 11'd1;
    randInputs(); layerEn = 0; frameStart = 1; dispPop = 0; dispLineEnd = 0; underrunClr = 0;
    doCycle();
    randInputs(); layerEn = 0; dispPop = 1; dispLineEnd = 0; underrunEn = 1; underrunClr = 1;
    doCycle();
    randInputs(); layerEn = 0; dispPop = 0; dispLineEnd = 0; underrunClr = 1;
    doCycle();
    randInputs(); layerEn = 0; dispPop = 1; dispLineEnd = 0; underrunEn = 0; underrunClr = 0;
    doCycle();

    // directed line shapes: exact burst, burst plus one, wide pitch, single byte
    runFrame(64'h0000_1000, 64, 64, 3);
    runFrame(64'h0000_2000, 65, 128, 2);
    runFrame(64'h0001_0000, 1, 4000, 4);
    runFrame(64'hFFFF_FFC0, 200, 256, 3);   // address wraps
    // R11: empty frames
    runFrame(64'h0000_3000, 0, 64, 4);
    runFrame(64'h0000_3000, 100, 128, 0);

    // R10: grants and consumes collide on most cycles
    kReady = 100; kFree = 100; kPop = 100; kLineEnd = 0; kEn = 100;
    runFrame(64'h0002_0000, 256, 256, 4);
    // R9: frequent line ends so discards meet grants
    kReady = 90; kPop = 60; kLineEnd = 20;
    runFrame(64'h0003_0000, 160, 192, 5);
    // layerEn pauses and a nearly full FIFO
    kEn = 40; kFree = 30; kReady = 50; kPop = 20; kLineEnd = 3;
    runFrame(64'h0004_0000, 300, 320, 3);

    // constrained random frames
    for (int f = 0; f < 40; f++) begin
      int len, pitch, cnt;
      kReady   = $urandom_range(100, 30);
      kFree    = $urandom_range(100, 40);
      kPop     = $urandom_range(80, 5);
      kLineEnd = $urandom_range(10);
      kClr     = $urandom_range(10);
      kEn      = $urandom_range(100, 60);
      kUrEn    = $urandom_range(100);
      len      = ($urandom_range(19) == 0) ? 0 : $urandom_range(300, 1);
      pitch    = len + $urandom_range(128);
      cnt      = ($urandom_range(19) == 0) ? 0 : $urandom_range(6, 1);
      runFrame(longint'($urandom()), len, pitch, cnt);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule